// File: doc/BRIEF.md
# Converter Processor Bus Port

This block is the processor-facing side of a data converter. A host reaches it through a 10-bit data bus, two chip selects of opposite polarity and a two-bit address. Through this bus the host loads two configuration words and reads converted samples out of the sample FIFO. The configuration words drive the rest of the converter: single-shot or free-running conversion, input channel choice, FIFO trigger level and output number format.

The strobe protocol can be programmed. In combined style one line gives the direction of each access: low writes, high reads, and chip select frames the access. In separate style the same line is an active-low write strobe and a second active-low line strobes reads. The style is undefined after reset, so the interface ignores every read until one write has completed. That first write is accepted in either style because both styles treat a low level on the shared line as a write.

Samples are held in the FIFO as straight binary. On the way out to the bus they can be converted to two's complement by inverting the top bit. Every finished read of the data port removes one word from the FIFO.

Top module: `proc_bus_port`

## Requirements
- R1: The port counts as selected only while `sel_n` is 0 and `sel_p` is 1. With any other combination, `bus_oe` stays 0 and nothing on the bus is written.
- R2: Reset clears both configuration words to zero. This gives continuous mode, channel code 00 (channel A single-ended), binary format and trigger code 00 (level 1), with `bus_oe` and `fifo_pop` at 0.
- R3: From reset until the first write completes, reads neither drive the bus nor pop the FIFO. The first write is recognised as the shared line held low while selected, in either style.
- R4: In combined style (word 0 bit 0 = 0), a selected access with `wstrb` low is a write and with `wstrb` high is a read, and `rstrb_n` is ignored. A write takes effect only when its phase ends (line high or deselect).
- R5: In separate style (word 0 bit 0 = 1), `wstrb` is an active-low write strobe and `rstrb_n` an active-low read strobe. When both are low the access is a write and the bus is not driven.
- R6: The address map is fixed. Address 0 is word 0 and address 1 is word 1, both read/write. Address 2 is the data port, read-only, and writes to it are ignored. Address 3 reads as zero and ignores writes.
- R7: Word 0 bit 1 drives `conv_single`, and bit 2 drives `twos_fmt`. Word 1 bits [1:0] drive `chan_sel`, and bits [3:2] drive `trig_code`.
- R8: Data-port reads return the FIFO head unchanged in binary format. In two's complement format the top bit is inverted, so 3FFh reads as 1FFh, 200h as 000h and 000h as 200h.
- R9: A completed data-port read pops exactly one word. `fifo_pop` pulses for one cycle, in the cycle after the clock edge at which the read phase ends, and only if `fifo_empty` is low at that edge. Reads of other addresses never pop.
- R10: A written value appears on the configuration outputs from the first clock edge after its write phase ends, and is stable otherwise. A read that starts in the same cycle already sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| port_addr | input | 2 | Register / data port address |
| wstrb | input | 1 | Direction line (combined style) or active-low write strobe (separate style) |
| rstrb_n | input | 1 | Active-low read strobe, separate style only |
| bus_in | input | DATA_W | Data from host |
| bus_out | output | DATA_W | Data to host |
| bus_oe | output | 1 | Bus drive enable |
| fifo_data | input | DATA_W | FIFO head word, binary |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | One-cycle FIFO read request |
| conv_single | output | 1 | Single-conversion mode when 1 |
| twos_fmt | output | 1 | Two's complement output format |
| chan_sel | output | 2 | Input channel code |
| trig_code | output | 2 | FIFO trigger level code |

## Verification
Two functions can fall in the same cycle: the commit of a configuration write and the start of a read. In combined style this happens when the host raises the direction line while staying selected. The bench provokes it by writing a new output format and, with no gap, turning the access into a data-port read. It judges the first word read against the format that was just written, and then checks that the read still pops when the host deselects. A behavioural model tracks both configuration words, the armed state and the pending pop, and is compared with the bus enable, the read data and every configuration output on every clock.

// File: rtl/proc_bus_port.sv
module proc_bus_port #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic [1:0]        port_addr,
  input  logic              wstrb,
  input  logic              rstrb_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              conv_single,
  output logic              twos_fmt,
  output logic [1:0]        chan_sel,
  output logic [1:0]        trig_code
);

  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [1:0] A_CFG0 = 2'd0;
  localparam logic [1:0] A_CFG1 = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  logic [DATA_W-1:0] cfg0, cfg1, wr_data_q;
  logic [1:0]        wr_addr_q, rd_addr_q;
  logic              armed, wr_q, rd_q;

  wire selected = !sel_n && sel_p;
  wire wr_now   = selected && !wstrb;
  wire rd_now   = armed && selected && !wr_now && (cfg0[0] ? !rstrb_n : wstrb);
  wire wr_done  = wr_q && !wr_now;
  wire rd_done  = rd_q && !rd_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0      <= '0;
      cfg1      <= '0;
      wr_data_q <= '0;
      wr_addr_q <= '0;
      rd_addr_q <= '0;
      armed     <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      fifo_pop  <= 1'b0;
    end else begin
      wr_q     <= wr_now;
      rd_q     <= rd_now;
      fifo_pop <= rd_done && (rd_addr_q == A_DATA) && !fifo_empty;
      if (wr_now) begin
        wr_addr_q <= port_addr;
        wr_data_q <= bus_in;
      end
      if (rd_now) rd_addr_q <= port_addr;
      if (wr_done) begin
        armed <= 1'b1;
        if (wr_addr_q == A_CFG0) cfg0 <= wr_data_q;
        if (wr_addr_q == A_CFG1) cfg1 <= wr_data_q;
      end
    end
  end

  always_comb begin
    case (port_addr)
      A_CFG0:  bus_out = cfg0;
      A_CFG1:  bus_out = cfg1;
      A_DATA:  bus_out = twos_fmt ? (fifo_data ^ TOP_BIT) : fifo_data;
      default: bus_out = '0;
    endcase
  end

  assign bus_oe      = rd_now;
  assign conv_single = cfg0[1];
  assign twos_fmt    = cfg0[2];
  assign chan_sel    = cfg1[1:0];
  assign trig_code   = cfg1[3:2];

  assert_oe_selected_R1: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!sel_n && sel_p));

  assert_quiet_until_armed_R3: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (!bus_oe && !fifo_pop));

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (selected && !wstrb) |-> !bus_oe);

  assert_single_pop_R9: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_done |=> ($stable(cfg0) && $stable(cfg1)));

endmodule

// File: tb/test_proc_bus_port.sv
module test_proc_bus_port;
  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, sel_p = 1'b0;
  logic [1:0] port_addr = 2'd0;
  logic wstrb = 1'b1, rstrb_n = 1'b1;
  logic [9:0] bus_in = '0, fifo_data = '0;
  logic fifo_empty = 1'b1;
  logic [9:0] bus_out;
  logic bus_oe, fifo_pop, conv_single, twos_fmt;
  logic [1:0] chan_sel, trig_code;

  int checks = 0, errors = 0;
  bit finished = 0;

  proc_bus_port #(.DATA_W(10)) i_proc_bus_port (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sel_p(sel_p), .port_addr(port_addr),
    .wstrb(wstrb), .rstrb_n(rstrb_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .conv_single(conv_single), .twos_fmt(twos_fmt),
    .chan_sel(chan_sel), .trig_code(trig_code));

  always #4 clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_init, m_wr, m_rd, m_pop;
  int m_c0, m_c1, m_wd, m_wa, m_ra;

  function automatic bit m_sel();
    return (sel_n == 1'b0) && (sel_p == 1'b1);
  endfunction

  function automatic bit m_read_now();
    bit sep;
    sep = (m_c0 % 2) == 1;
    return m_init && m_sel() && wstrb && (sep ? !rstrb_n : 1'b1);
  endfunction

  function automatic int m_data();
    if (port_addr == 0) return m_c0;
    if (port_addr == 1) return m_c1;
    if (port_addr == 2) return ((m_c0 / 4) % 2 == 1) ? (int'(fifo_data) + 512) % 1024 : int'(fifo_data);
    return 0;
  endfunction

  always @(posedge clk) begin
    bit wr, rd, pn;
    if (rst) begin
      m_init = 0; m_wr = 0; m_rd = 0; m_pop = 0;
      m_c0 = 0; m_c1 = 0; m_wd = 0; m_wa = 0; m_ra = 0;
    end else begin
      wr = m_sel() && !wstrb;
      rd = m_read_now();
      pn = m_rd && !rd && m_ra == 2 && !fifo_empty;
      if (m_wr && !wr) begin
        m_init = 1;
        if (m_wa == 0) m_c0 = m_wd;
        if (m_wa == 1) m_c1 = m_wd;
      end
      if (wr) begin m_wa = port_addr; m_wd = bus_in; end
      if (rd) m_ra = port_addr;
      m_wr = wr; m_rd = rd; m_pop = pn;
    end
  end

  always @(negedge clk) begin
    #2;
    if (!rst && !finished) begin
      check("R1 bus_oe vs model", bus_oe, m_read_now());
      if (bus_oe) check("R6 bus_out vs model", bus_out, m_data());
      check("R9 fifo_pop vs model", fifo_pop, m_pop);
      check("R7 conv_single vs model", conv_single, (m_c0 / 2) % 2);
      check("R7 twos_fmt vs model", twos_fmt, (m_c0 / 4) % 2);
      check("R7 chan_sel vs model", chan_sel, m_c1 % 4);
      check("R7 trig_code vs model", trig_code, (m_c1 / 4) % 4);
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic select_on(logic [1:0] a);
    sel_n = 1'b0; sel_p = 1'b1; port_addr = a;
  endtask

  task automatic select_off();
    sel_n = 1'b1; sel_p = 1'b0;
  endtask

  task automatic wr_sep(logic [1:0] a, logic [9:0] d);
    step(); select_on(a); bus_in = d; wstrb = 1'b0;
    step(); step(); wstrb = 1'b1;
    step(); select_off();
    step();
  endtask

  task automatic rd_sep(logic [1:0] a, output int v, output int oe, output int pop);
    step(); select_on(a); rstrb_n = 1'b0;
    step(); step(); v = bus_out; oe = bus_oe; rstrb_n = 1'b1;
    step(); pop = fifo_pop; select_off();
    step();
  endtask

  task automatic rd_comb(logic [1:0] a, output int v, output int oe, output int pop);
    step(); select_on(a); wstrb = 1'b1;
    step(); step(); v = bus_out; oe = bus_oe; select_off();
    step(); pop = fifo_pop;
    step();
  endtask

  initial begin
    int v, oe, pop;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R2 conv_single default", conv_single, 0);
    check("R2 twos_fmt default", twos_fmt, 0);
    check("R2 chan_sel default", chan_sel, 0);
    check("R2 trig_code default", trig_code, 0);
    check("R2 bus_oe default", bus_oe, 0);
    check("R2 fifo_pop default", fifo_pop, 0);

    fifo_data = 10'h3FF; fifo_empty = 1'b0;
    rd_sep(2'd2, v, oe, pop);
    check("R3 no drive before first write", oe, 0);
    check("R3 no pop before first write", pop, 0);
    rd_comb(2'd0, v, oe, pop);
    check("R3 combined read ignored before first write", oe, 0);

    wr_sep(2'd0, 10'h001);
    rd_sep(2'd0, v, oe, pop);
    check("R3 first write accepted, bus driven", oe, 1);
    check("R5 separate read of word 0", v, 10'h001);

    wr_sep(2'd1, 10'h00E);
    check("R7 chan_sel from word 1", chan_sel, 2);
    check("R7 trig_code from word 1", trig_code, 3);

    rd_sep(2'd2, v, oe, pop);
    check("R8 binary data passthrough", v, 10'h3FF);
    check("R9 data read pops", pop, 1);
    fifo_empty = 1'b1;
    rd_sep(2'd2, v, oe, pop);
    check("R9 no pop when empty", pop, 0);
    fifo_empty = 1'b0;
    rd_sep(2'd1, v, oe, pop);
    check("R6 readback of word 1", v, 10'h00E);
    check("R9 no pop on register read", pop, 0);

    step(); sel_n = 1'b0; sel_p = 1'b0; port_addr = 2'd1; bus_in = 10'h3FF; wstrb = 1'b0;
    step(); step(); wstrb = 1'b1;
    step(); sel_n = 1'b1; rstrb_n = 1'b0; sel_p = 1'b1;
    step(); check("R1 no drive with sel_n high", bus_oe, 0);
    rstrb_n = 1'b1; select_off();
    rd_sep(2'd1, v, oe, pop);
    check("R1 deselected write ignored", v, 10'h00E);

    wr_sep(2'd2, 10'h3FF);
    wr_sep(2'd3, 10'h3FF);
    rd_sep(2'd0, v, oe, pop);
    check("R6 writes to 2 and 3 leave word 0", v, 10'h001);
    rd_sep(2'd1, v, oe, pop);
    check("R6 writes to 2 and 3 leave word 1", v, 10'h00E);
    rd_sep(2'd3, v, oe, pop);
    check("R6 address 3 reads zero", v, 0);

    step(); select_on(2'd0); bus_in = 10'h001; wstrb = 1'b0; rstrb_n = 1'b0;
    step(); step(); check("R5 both strobes low is a write", bus_oe, 0);
    wstrb = 1'b1;
    step(); check("R5 read follows after write strobe", bus_oe, 1);
    check("R5 read data after overlapping write", bus_out, 10'h001);
    rstrb_n = 1'b1; select_off();
    step();

    wr_sep(2'd0, 10'h006);
    check("R7 single-conversion bit", conv_single, 1);
    check("R7 two's complement bit", twos_fmt, 1);

    fifo_data = 10'h3FF;
    rd_comb(2'd2, v, oe, pop);
    check("R4 combined read drives bus", oe, 1);
    check("R8 3FF as two's complement", v, 10'h1FF);
    check("R9 combined data read pops", pop, 1);
    fifo_data = 10'h200;
    rd_comb(2'd2, v, oe, pop);
    check("R8 200 as two's complement", v, 10'h000);
    fifo_data = 10'h000;
    rd_comb(2'd2, v, oe, pop);
    check("R8 000 as two's complement", v, 10'h200);

    step(); rstrb_n = 1'b0; select_on(2'd0); wstrb = 1'b1;
    step(); step(); check("R4 rstrb_n has no role in combined read", bus_oe, 1);
    select_off(); rstrb_n = 1'b1;
    step();

    fifo_data = 10'h200;
    step(); select_on(2'd0); bus_in = 10'h000; wstrb = 1'b0;
    step(); step(); check("R4 value held until write ends", twos_fmt, 1);
    wstrb = 1'b1; port_addr = 2'd2;
    step();
    check("R10 read in commit cycle drives bus", bus_oe, 1);
    check("R10 read in commit cycle uses new format", bus_out, 10'h200);
    check("R10 mode updated at commit", conv_single, 0);
    select_off();
    step(); check("R9 pop after merged read", fifo_pop, 1);
    step(); check("R9 pop lasts one cycle", fifo_pop, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule